// File: doc/BRIEF.md
# Power mode and reset-flag controller

This block governs the low-power states of a small microcontroller and keeps its power-monitoring status. It holds an 8-bit control/status register that the CPU reads and writes. Writing the idle bit halts the CPU clock while the oscillator and peripherals keep running. Writing the power-down bit also stops the oscillator. The register's value after a reset depends on the reset cause. Two sticky flags record power-on and brownout events.

Exit from idle follows any enabled interrupt. Exit from power-down needs an interrupt that outranks the one in service, an enabled brownout interrupt, or a reset. After a power-down wake the oscillator restarts at once. The CPU clock stays gated for a settling count that depends on the oscillator type. A brownout can be set up as a reset, as a wake-up interrupt, or switched off. A watchdog overflow resets the block from any state, power-down included.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset value by cause. Asserting rst_ni or por_i loads 0x30. A brownout reset loads 0x20. ext_rst_i or wdt_ovf_i loads 0x00. When causes coincide, power-on wins over brownout, and brownout wins over the other causes.
- R2: Register layout, bit 7 down to 0: baud-double, frame-error-select, brownout flag, power-on flag, general flag 1, general flag 0, power-down, idle. A write in run state stores bits 7, 6, 3 and 2 as written. Writing 0 to bit 5 or bit 4 clears that flag; writing 1 leaves it unchanged. Only hardware sets the flags.
- R3: Writes are ignored while the block is in idle, power-down or wake-settling.
- R4: A write in run state with bit 0 = 1 and bit 1 = 0 enters idle from the next cycle: cpu_clk_en_o = 0 and osc_en_o = 1.
- R5: A write in run state with bit 1 = 1 enters power-down: cpu_clk_en_o = 0 and osc_en_o = 0. If bit 0 is also set, power-down wins and bit 0 reads back 0. Bit 1 reads 1 exactly while the oscillator is stopped.
- R6: Idle ends on the cycle after irq_req_i = 1, whatever irq_prio_hi_i is, or after an enabled brownout interrupt. Bit 0 then clears.
- R7: Power-down ends only on irq_req_i = 1 with irq_prio_hi_i = 1, on an enabled brownout interrupt, or on a reset. Bit 1 clears and osc_en_o rises on the next cycle. cpu_clk_en_o stays 0 for 1024 cycles when osc_xtal_i = 1, or 256 cycles when osc_xtal_i = 0.
- R8: With bo_irq_mode_i = 0, a brownout event pulses rst_req_o on the next cycle, loads 0x20 and returns the block to run state.
- R9: With bo_irq_mode_i = 1, a brownout event sets bit 5. If bo_irq_en_i = 1, it also pulses bo_irq_o on the next cycle and wakes the block. If bo_irq_en_i = 0, the block stays in power-down.
- R10: While bo_dis_i = 1, brownout events change nothing: no reset request, no interrupt and no flag.
- R11: ext_rst_i or wdt_ovf_i pulses rst_req_o on the next cycle and returns the block to run state from any state, power-down included. por_i also pulses rst_req_o.
- R12: Bits 7, 6, 3 and 2 have no effect on any mode transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| por_i | input | 1 | Power-on detect event |
| ext_rst_i | input | 1 | Other reset source |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| bo_event_i | input | 1 | Brownout detected |
| bo_dis_i | input | 1 | Brownout detection off |
| bo_irq_mode_i | input | 1 | 1: brownout is an interrupt, 0: brownout is a reset |
| bo_irq_en_i | input | 1 | Brownout interrupt enabled |
| irq_req_i | input | 1 | An enabled interrupt is pending |
| irq_prio_hi_i | input | 1 | Pending interrupt outranks the one in service |
| osc_xtal_i | input | 1 | 1: crystal oscillator, 0: RC or external clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register contents |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| rst_req_o | output | 1 | Reset request pulse |
| bo_irq_o | output | 1 | Brownout interrupt pulse |

## Verification
Every one of the 256 write values is applied from run state. This separates values that enter idle, values that enter power-down, and values with both bits set, where power-down must win. The bit-0 and bit-1 combinations are repeated under every mix of general and baud bits. In each mode, a low-priority interrupt is applied first. It must end idle and must leave power-down untouched, which tells the two exit rules apart. The settling length is then counted for both oscillator types. Separate sequences apply each reset cause, alone and together, to distinguish the three reset values and their priority. They also cover brownout with the interrupt enabled, disabled, and with detection off.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W   = 8;
  localparam int B_BAUD  = 7;
  localparam int B_FESEL = 6;
  localparam int B_BOF   = 5;
  localparam int B_POF   = 4;
  localparam int B_GP1   = 3;
  localparam int B_GP0   = 2;
  localparam int B_PD    = 1;
  localparam int B_IDL   = 0;
  localparam logic [REG_W-1:0] POR_VAL = 8'h30;
  localparam logic [REG_W-1:0] BOR_VAL = 8'h20;

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_PDOWN, ST_WAKE} pm_state_e;
  typedef enum logic [1:0] {RC_NONE, RC_POR, RC_BOR, RC_OTHER} rst_cause_e;
endpackage

// File: rtl/pwr_evt.sv
module pwr_evt
  import pwr_mode_pkg::*;
(
  input  logic       por_i,
  input  logic       ext_rst_i,
  input  logic       wdt_ovf_i,
  input  logic       bo_event_i,
  input  logic       bo_dis_i,
  input  logic       bo_irq_mode_i,
  input  logic       bo_irq_en_i,
  input  logic       irq_req_i,
  input  logic       irq_prio_hi_i,
  output rst_cause_e cause_o,
  output logic       bo_flag_o,
  output logic       bo_irq_o,
  output logic       wake_idle_o,
  output logic       wake_pd_o
);
  logic bo_live, bo_rst;

  assign bo_live   = bo_event_i & ~bo_dis_i;
  assign bo_rst    = bo_live & ~bo_irq_mode_i;
  assign bo_flag_o = bo_live & bo_irq_mode_i;
  assign bo_irq_o  = bo_flag_o & bo_irq_en_i;

  // power-on > brownout > other sources
  always_comb begin
    if (por_i)                       cause_o = RC_POR;
    else if (bo_rst)                 cause_o = RC_BOR;
    else if (ext_rst_i || wdt_ovf_i) cause_o = RC_OTHER;
    else                             cause_o = RC_NONE;
  end

  assign wake_idle_o = irq_req_i | bo_irq_o;
  assign wake_pd_o   = (irq_req_i & irq_prio_hi_i) | bo_irq_o;
endmodule

// File: rtl/pwr_reg.sv
module pwr_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rst_cause_e       cause_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             bo_flag_i,
  input  logic             clr_pd_i,
  input  logic             clr_idl_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q, d;

  always_comb begin
    d = q;
    unique case (cause_i)
      RC_POR:   d = POR_VAL;
      RC_BOR:   d = BOR_VAL;
      RC_OTHER: d = '0;
      default: begin
        if (wr_i) begin
          d[B_BAUD]  = wdata_i[B_BAUD];
          d[B_FESEL] = wdata_i[B_FESEL];
          d[B_GP1]   = wdata_i[B_GP1];
          d[B_GP0]   = wdata_i[B_GP0];
          d[B_BOF]   = q[B_BOF] & wdata_i[B_BOF];  // software may only clear
          d[B_POF]   = q[B_POF] & wdata_i[B_POF];
          d[B_PD]    = wdata_i[B_PD];
          d[B_IDL]   = wdata_i[B_IDL] & ~wdata_i[B_PD];
        end
        if (bo_flag_i) d[B_BOF] = 1'b1;
        if (clr_pd_i)  d[B_PD]  = 1'b0;
        if (clr_idl_i) d[B_IDL] = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= POR_VAL;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mode_pkg::*;
#(
  parameter int XTAL_CYC = 1024,
  parameter int RC_CYC   = 256
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rst_evt_i,
  input  logic      go_pd_i,
  input  logic      go_idl_i,
  input  logic      wake_idle_i,
  input  logic      wake_pd_i,
  input  logic      xtal_i,
  output pm_state_e state_o
);
  localparam int MAX_CYC = (XTAL_CYC > RC_CYC) ? XTAL_CYC : RC_CYC;
  localparam int CW      = $clog2(MAX_CYC) + 1;
  localparam logic [CW-1:0] XTAL_LD = CW'(XTAL_CYC - 1);
  localparam logic [CW-1:0] RC_LD   = CW'(RC_CYC - 1);

  pm_state_e state, nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:   if (go_pd_i) nxt = ST_PDOWN; else if (go_idl_i) nxt = ST_IDLE;
      ST_IDLE:  if (wake_idle_i) nxt = ST_RUN;
      ST_PDOWN: if (wake_pd_i) nxt = ST_WAKE;
      ST_WAKE:  if (cnt == '0) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
    if (rst_evt_i) nxt = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_PDOWN && nxt == ST_WAKE) cnt <= xtal_i ? XTAL_LD : RC_LD;
      else if (state == ST_WAKE && cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign state_o = state;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int XTAL_CYC = 1024,
  parameter int RC_CYC   = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  input  logic             bo_event_i,
  input  logic             bo_dis_i,
  input  logic             bo_irq_mode_i,
  input  logic             bo_irq_en_i,
  input  logic             irq_req_i,
  input  logic             irq_prio_hi_i,
  input  logic             osc_xtal_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             cpu_clk_en_o,
  output logic             osc_en_o,
  output logic             rst_req_o,
  output logic             bo_irq_o
);
  rst_cause_e cause;
  pm_state_e  state;
  logic bo_flag, bo_irq, wake_idle, wake_pd, rst_evt, run, wr;
  logic rst_req_q, bo_irq_q;

  pwr_evt u_evt (
    .por_i, .ext_rst_i, .wdt_ovf_i, .bo_event_i, .bo_dis_i,
    .bo_irq_mode_i, .bo_irq_en_i, .irq_req_i, .irq_prio_hi_i,
    .cause_o(cause), .bo_flag_o(bo_flag), .bo_irq_o(bo_irq),
    .wake_idle_o(wake_idle), .wake_pd_o(wake_pd)
  );

  assign rst_evt = (cause != RC_NONE);
  assign run     = (state == ST_RUN);
  assign wr      = reg_we_i & run;

  pwr_fsm #(.XTAL_CYC(XTAL_CYC), .RC_CYC(RC_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .rst_evt_i  (rst_evt),
    .go_pd_i    (wr & reg_wdata_i[B_PD]),
    .go_idl_i   (wr & reg_wdata_i[B_IDL]),
    .wake_idle_i(wake_idle),
    .wake_pd_i  (wake_pd),
    .xtal_i     (osc_xtal_i),
    .state_o    (state)
  );

  pwr_reg u_reg (
    .clk_i, .rst_ni,
    .cause_i  (cause),
    .wr_i     (wr),
    .wdata_i  (reg_wdata_i),
    .bo_flag_i(bo_flag),
    .clr_pd_i (state == ST_PDOWN && wake_pd),
    .clr_idl_i(state == ST_IDLE && wake_idle),
    .q_o      (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      bo_irq_q  <= 1'b0;
    end else begin
      rst_req_q <= rst_evt;
      bo_irq_q  <= bo_irq;
    end
  end

  assign rst_req_o    = rst_req_q;
  assign bo_irq_o     = bo_irq_q;
  assign cpu_clk_en_o = run;
  assign osc_en_o     = (state != ST_PDOWN);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       ext_rst_i,
  input logic       wdt_ovf_i,
  input logic       bo_event_i,
  input logic       bo_dis_i,
  input logic       bo_irq_mode_i,
  input logic       irq_req_i,
  input logic       reg_we_i,
  input logic [7:0] reg_rdata_o,
  input logic       cpu_clk_en_o,
  input logic       osc_en_o,
  input logic       rst_req_o,
  input logic       bo_irq_o
);
  logic bo_as_rst;
  assign bo_as_rst = bo_event_i && !bo_dis_i && !bo_irq_mode_i;

  p_por_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (reg_rdata_o == 8'h30) && rst_req_o);

  p_bor_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_as_rst && !por_i) |=> (reg_rdata_o == 8'h20) && rst_req_o && cpu_clk_en_o);

  p_other_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ext_rst_i || wdt_ovf_i) && !por_i && !bo_as_rst)
      |=> (reg_rdata_o == 8'h00) && rst_req_o && cpu_clk_en_o);

  p_bo_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_dis_i && !por_i && !ext_rst_i && !wdt_ovf_i) |=> !rst_req_o && !bo_irq_o);

  p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[5] && !reg_we_i && !ext_rst_i && !wdt_ovf_i) |=> reg_rdata_o[5]);

  p_pd_osc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1] == !osc_en_o);

  p_one_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rdata_o[1] && reg_rdata_o[0]));

  p_idle_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] |-> osc_en_o && !cpu_clk_en_o);

  p_pd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !irq_req_i && !bo_event_i && !por_i && !ext_rst_i && !wdt_ovf_i)
      |=> !osc_en_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i, .rst_ni, .por_i, .ext_rst_i, .wdt_ovf_i, .bo_event_i, .bo_dis_i,
  .bo_irq_mode_i, .irq_req_i, .reg_we_i, .reg_rdata_o, .cpu_clk_en_o,
  .osc_en_o, .rst_req_o, .bo_irq_o
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_i = 0, ext_rst_i = 0, wdt_ovf_i = 0;
  logic bo_event_i = 0, bo_dis_i = 0, bo_irq_mode_i = 0, bo_irq_en_i = 0;
  logic irq_req_i = 0, irq_prio_hi_i = 0, osc_xtal_i = 0, reg_we_i = 0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic cpu_clk_en_o, osc_en_o, rst_req_o, bo_irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk_i(clk), .rst_ni, .por_i, .ext_rst_i, .wdt_ovf_i, .bo_event_i,
    .bo_dis_i, .bo_irq_mode_i, .bo_irq_en_i, .irq_req_i, .irq_prio_hi_i,
    .osc_xtal_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .cpu_clk_en_o,
    .osc_en_o, .rst_req_o, .bo_irq_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wait_run(output int n);
    n = 0;
    while (!cpu_clk_en_o && osc_en_o && n < 3000) begin n++; tick(); end
  endtask

  initial begin
    int n;
    repeat (3) tick();
    chk("R1 async reset value", reg_rdata_o, 8'h30);
    rst_ni = 1'b1;
    tick();
    chk("R1 reset outputs", {cpu_clk_en_o, osc_en_o, rst_req_o, bo_irq_o}, 4'b1100);

    wr(8'h00);
    chk("R2 flags cleared", reg_rdata_o, 8'h00);
    wr(8'h3C);
    chk("R2 flags not settable", reg_rdata_o, 8'h0C);
    wr(8'h00);

    // sweep of every write value from run state
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b, expv;
      b = v[7:0];
      expv = (b & 8'hCC) | (b[1] ? 8'h02 : (b[0] ? 8'h01 : 8'h00));
      osc_xtal_i = b[7];
      wr(b);
      chk("R2 R5 readback", reg_rdata_o, expv);
      chk("R4 R5 R12 cpu clk", cpu_clk_en_o, !(b[1] | b[0]));
      chk("R5 R12 osc", osc_en_o, !b[1]);
      if (b[1] || b[0]) begin
        irq_req_i = 1; irq_prio_hi_i = 0; tick(); irq_req_i = 0;
        if (b[1]) begin
          chk("R7 low prio no wake", {osc_en_o, reg_rdata_o}, {1'b0, expv});
          irq_req_i = 1; irq_prio_hi_i = 1; tick(); irq_req_i = 0; irq_prio_hi_i = 0;
          chk("R7 osc restarts", {osc_en_o, cpu_clk_en_o}, 2'b10);
          wait_run(n);
          chk("R7 settle count", n, b[7] ? 16'd1024 : 16'd256);
        end
        chk("R6 R7 exit readback", {cpu_clk_en_o, reg_rdata_o}, {1'b1, b & 8'hCC});
      end
      wr(8'h00);
    end

    // R3: writes ignored outside run state
    wr(8'h01); wr(8'hCC);
    chk("R3 ignored in idle", reg_rdata_o, 8'h01);
    irq_req_i = 1; tick(); irq_req_i = 0;
    chk("R6 idle exit", {cpu_clk_en_o, reg_rdata_o}, 9'h100);
    osc_xtal_i = 0;
    wr(8'h02); wr(8'h0C);
    chk("R3 ignored in power-down", reg_rdata_o, 8'h02);

    // R9: brownout as interrupt
    bo_irq_mode_i = 1; bo_irq_en_i = 0;
    bo_event_i = 1; tick(); bo_event_i = 0;
    chk("R9 disabled irq no wake", {bo_irq_o, osc_en_o, reg_rdata_o}, 10'h022);
    bo_irq_en_i = 1;
    bo_event_i = 1; tick(); bo_event_i = 0;
    chk("R9 irq wakes", {bo_irq_o, osc_en_o, cpu_clk_en_o, reg_rdata_o}, {3'b110, 8'h20});
    tick();
    chk("R9 irq single pulse", bo_irq_o, 1'b0);
    wait_run(n);
    chk("R9 settle rc", n, 16'd255);
    wr(8'h00);

    // R10: detection off
    bo_dis_i = 1;
    bo_event_i = 1; tick(); bo_event_i = 0;
    chk("R10 irq mode ignored", {bo_irq_o, rst_req_o, reg_rdata_o}, 10'h000);
    bo_irq_mode_i = 0;
    bo_event_i = 1; tick(); bo_event_i = 0;
    chk("R10 reset mode ignored", {bo_irq_o, rst_req_o, reg_rdata_o}, 10'h000);
    bo_dis_i = 0;

    // R8: brownout as reset
    wr(8'h01);
    bo_event_i = 1; tick(); bo_event_i = 0;
    chk("R8 brownout reset", {rst_req_o, cpu_clk_en_o, reg_rdata_o}, {2'b11, 8'h20});
    tick();
    chk("R8 request pulse ends", rst_req_o, 1'b0);

    // R11: watchdog in power-down, external reset
    wr(8'h22);
    chk("R11 in power-down", osc_en_o, 1'b0);
    wdt_ovf_i = 1; tick(); wdt_ovf_i = 0;
    chk("R11 watchdog reset", {rst_req_o, cpu_clk_en_o, osc_en_o, reg_rdata_o}, {3'b111, 8'h00});
    por_i = 1; tick(); por_i = 0;
    chk("R1 R11 power-on event", {rst_req_o, reg_rdata_o}, {1'b1, 8'h30});
    ext_rst_i = 1; tick(); ext_rst_i = 0;
    chk("R1 R11 external reset", {rst_req_o, reg_rdata_o}, {1'b1, 8'h00});
    por_i = 1; bo_event_i = 1; tick(); por_i = 0; bo_event_i = 0;
    chk("R1 power-on over brownout", reg_rdata_o, 8'h30);
    wdt_ovf_i = 1; bo_event_i = 1; tick(); wdt_ovf_i = 0; bo_event_i = 0;
    chk("R1 brownout over watchdog", reg_rdata_o, 8'h20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule